// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block loads one fixed word into every location of a connection memory, so software does not have to write each address itself. A control register, written as a whole word, holds three things: an arm bit, a start bit and a small pattern field. With both arm and start set, an address sequencer walks the memory from the lowest address to the highest. Every word it writes carries the pattern in its top bits and zeros in all lower bits. After the last address is written, the engine clears the start bit on its own and raises a one-cycle done pulse.

The memory has a single write port. The engine shares it with the processor path. The engine only writes in cycles where the free-slot strobe is high. Tying the strobe high writes one word per clock. Driving the strobe once per frame slot spreads the sweep over the frame, and at the default depth the sweep then fits inside two frames. While the engine owns the port, processor writes are dropped. If the arm bit is cleared during a sweep, the sweep stops and the start bit clears.

Top module: `cmf_block_init`

## Requirements
- R1: After reset the control register reads all zeros, and busy, done and mem_we are low.
- R2: Every word the engine writes has control bits [WORD_W-1:WORD_W-PAT_W] (bits 15:13 by default) in the same top bits, and zero in every lower bit.
- R3: One complete sweep writes each address from 0 to DEPTH-1 exactly once, in ascending order, with no other engine writes.
- R4: The engine writes only in cycles where slot_en is high, and one completed sweep uses exactly DEPTH strobe cycles.
- R5: In the cycle after the write to address DEPTH-1, the start bit (control bit 0) reads 0, busy is low, and done is high for exactly one cycle.
- R6: If the start bit is written as 1 while the arm bit (control bit 1) is 0, the engine makes no write and the start bit reads 0 one cycle later.
- R7: If the arm bit is written as 0 during a sweep, engine writes stop from the next cycle, the start bit clears, and no done pulse follows.
- R8: busy is high from the cycle after start and arm are both set until the start bit clears. While busy is high, a host write never reaches the memory port. While busy is low, a host write passes through in the same cycle with its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Loads cfg_data into the control register |
| cfg_data | input | WORD_W | Control word: bit 0 start, bit 1 arm, top PAT_W bits pattern |
| ctl_q | output | WORD_W | Current control register contents |
| slot_en | input | 1 | Free write slot strobe for the engine |
| host_we | input | 1 | Processor write request |
| host_addr | input | AW | Processor write address |
| host_wdata | input | WORD_W | Processor write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | WORD_W | Memory write data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a sweep completes |

## Verification
The bench builds the block with DEPTH = 16, keeping the default 16-bit word and 3-bit pattern. At that depth, complete sweeps, the wrap at the last address and the self-clear all fall within a few dozen cycles. This lets every pattern value class and strobe periods of one, two and three clocks be run end to end, and every stored word be compared. The small depth also lets an abort land in the middle of a sweep and a blocked host write land on an address the engine has already filled.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
   // Control register bit positions.
   localparam int CTL_START = 0;
   localparam int CTL_ARM   = 1;

   // Sweep state as seen from the control register.
   typedef enum logic [1:0] {
      CMF_IDLE    = 2'b00,
      CMF_UNARMED = 2'b01,
      CMF_ARMED   = 2'b10,
      CMF_RUN     = 2'b11
   } cmf_state_e;

   function automatic cmf_state_e cmf_state(input logic start, input logic arm);
      return cmf_state_e'({arm, start});
   endfunction
endpackage

// File: rtl/cmf_ctl_reg.sv
module cmf_ctl_reg #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              clr_start,
   output logic [WORD_W-1:0] q
);
   import cmf_pkg::*;

   logic [WORD_W-1:0] nxt;

   always_comb begin
      nxt = wr ? wdata : q;
      // The self-clear wins over a write landing in the same cycle.
      if (clr_start) nxt[CTL_START] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/cmf_addr_seq.sv
module cmf_addr_seq #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   assign last = run & step & (addr == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           addr <= '0;
      else if (!run)        addr <= '0;
      else if (step) begin
         if (addr == TOP)   addr <= '0;
         else               addr <= addr + AW'(1);
      end
   end
endmodule

// File: rtl/cmf_fill_word.sv
module cmf_fill_word #(
   parameter int WORD_W = 16,
   parameter int PAT_W  = 3
) (
   input  logic [PAT_W-1:0]  pat,
   output logic [WORD_W-1:0] word
);
   localparam int LSB = WORD_W - PAT_W;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i >= LSB) begin : g_pat
         assign word[i] = pat[i-LSB];
      end else begin : g_zero
         assign word[i] = 1'b0;
      end
   end
endmodule

// File: rtl/cmf_port_mux.sv
module cmf_port_mux #(
   parameter int AW     = 11,
   parameter int WORD_W = 16
) (
   input  logic              eng_own,
   input  logic              eng_we,
   input  logic [AW-1:0]     eng_addr,
   input  logic [WORD_W-1:0] eng_data,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [WORD_W-1:0] host_data,
   output logic              we,
   output logic [AW-1:0]     addr,
   output logic [WORD_W-1:0] data
);
   always_comb begin
      if (eng_own) begin
         we   = eng_we;
         addr = eng_addr;
         data = eng_data;
      end else begin
         we   = host_we;
         addr = host_addr;
         data = host_data;
      end
   end
endmodule

// File: rtl/cmf_block_init.sv
module cmf_block_init #(
   parameter int DEPTH  = 2048,
   parameter int WORD_W = 16,
   parameter int PAT_W  = 3,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LSB   = WORD_W - PAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [WORD_W-1:0] cfg_data,
   output logic [WORD_W-1:0] ctl_q,
   input  logic              slot_en,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done
);
   import cmf_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("cmf_block_init: DEPTH must be at least 2");
   end
   if (PAT_W < 1 || PAT_W > WORD_W - 2) begin : g_bad_pat
      $error("cmf_block_init: PAT_W must leave room for the start and arm bits");
   end

   cmf_state_e        state;
   logic              run;
   logic              last;
   logic              clr_start;
   logic              done_q;
   logic [AW-1:0]     eng_addr;
   logic [WORD_W-1:0] fill;

   assign state     = cmf_state(ctl_q[CTL_START], ctl_q[CTL_ARM]);
   assign run       = (state == CMF_RUN);
   assign clr_start = (state == CMF_UNARMED) | last;

   cmf_ctl_reg #(.WORD_W(WORD_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wdata     (cfg_data),
      .clr_start (clr_start),
      .q         (ctl_q)
   );

   cmf_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (slot_en),
      .addr  (eng_addr),
      .last  (last)
   );

   cmf_fill_word #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_fill (
      .pat  (ctl_q[WORD_W-1:LSB]),
      .word (fill)
   );

   cmf_port_mux #(.AW(AW), .WORD_W(WORD_W)) u_mux (
      .eng_own   (run),
      .eng_we    (slot_en),
      .eng_addr  (eng_addr),
      .eng_data  (fill),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_data (host_wdata),
      .we        (mem_we),
      .addr      (mem_addr),
      .data      (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= last;
   end

   assign busy = run;
   assign done = done_q;
endmodule

// File: rtl/cmf_block_init_chk.sv
module cmf_block_init_chk #(
   parameter int DEPTH  = 2048,
   parameter int WORD_W = 16,
   parameter int PAT_W  = 3,
   parameter int AW     = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [WORD_W-1:0] ctl_q,
   input logic              slot_en,
   input logic              mem_we,
   input logic [AW-1:0]     mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              busy,
   input logic              done
);
   localparam int LSB = WORD_W - PAT_W;
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   a_r2_fill_word: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mem_we |-> (mem_wdata[LSB-1:0] == '0) &&
                         (mem_wdata[WORD_W-1:LSB] == ctl_q[WORD_W-1:LSB]));

   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mem_we && (mem_addr != TOP) |=>
         !busy || !mem_we || (mem_addr == $past(mem_addr) + AW'(1)));

   a_r4_slot_gate: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !slot_en |-> !mem_we);

   a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ctl_q[0] && !busy);

   a_r5_done_after_top: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mem_we && (mem_addr == TOP) |=> done);

   a_r6_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[0] && !ctl_q[1] && !cfg_wr |=> !ctl_q[0]);
endmodule

bind cmf_block_init cmf_block_init_chk #(
   .DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W), .AW(AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .ctl_q     (ctl_q),
   .slot_en   (slot_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .busy      (busy),
   .done      (done)
);

// File: tb/cmf_block_init_test.sv
`timescale 1ns/100ps
module cmf_block_init_test;
   localparam int DEPTH  = 16;
   localparam int WORD_W = 16;
   localparam int PAT_W  = 3;
   localparam int AW     = $clog2(DEPTH);

   // Vector: {pattern[2:0], strobe period[1:0], host poke}
   localparam int NVEC = 4;
   localparam logic [5:0] VEC [NVEC] = '{
      {3'b101, 2'd1, 1'b1},
      {3'b010, 2'd2, 1'b0},
      {3'b111, 2'd3, 1'b0},
      {3'b000, 2'd1, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [WORD_W-1:0] cfg_data = '0;
   logic [WORD_W-1:0] ctl_q;
   logic              slot_en = 1'b0;
   logic              host_we = 1'b0;
   logic [AW-1:0]     host_addr = '0;
   logic [WORD_W-1:0] host_wdata = '0;
   logic              mem_we;
   logic [AW-1:0]     mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic              busy;
   logic              done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // Memory model and monitors.
   logic [WORD_W-1:0] model [DEPTH];
   int wcnt = 0, done_cnt = 0, gate_bad = 0, seq_bad = 0, slot_cnt = 0;
   int exp_next = 0;
   int slot_per = 1, phase = 0;

   cmf_block_init #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .ctl_q(ctl_q), .slot_en(slot_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
   );

   always #2.5 clk = ~clk;

   // Free-slot strobe, driven at the falling edge.
   always @(negedge clk) begin
      slot_en = (phase == 0);
      phase   = (phase + 1 >= slot_per) ? 0 : phase + 1;
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (mem_we) begin
            model[mem_addr] = mem_wdata;
            wcnt++;
            if (busy && !slot_en) gate_bad++;
            if (busy) begin
               if (int'(mem_addr) != exp_next) seq_bad++;
               exp_next = (exp_next + 1) % DEPTH;
            end
         end
         if (busy && slot_en) slot_cnt++;
         if (done) done_cnt++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int a = 0; a < DEPTH; a++) model[a] = '1;
      wcnt = 0; done_cnt = 0; gate_bad = 0; seq_bad = 0; slot_cnt = 0;
      exp_next = 0;
   endtask

   task automatic run_sweep(input logic [2:0] pat, input int per, input bit poke);
      logic [WORD_W-1:0] expw;
      int bad;
      expw = {pat, 13'b0};
      clear_model();
      slot_per = per;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_data = {pat, 11'b0, 2'b11};
      @(negedge clk);
      cfg_wr = 1'b0;
      #2;
      chk(busy == 1'b1, "R8 busy after start", 32'(busy), 1);
      for (int n = 0; n < 200 && done_cnt == 0; n++) begin
         @(negedge clk);
         if (poke && n == 6) begin
            host_we = 1'b1; host_addr = '0; host_wdata = 16'h1234;
         end
         if (poke && n == 7) host_we = 1'b0;
         #2;
         if (poke && n == 6)
            chk(mem_wdata != 16'h1234, "R8 host blocked while busy",
                32'(mem_wdata), {pat, 13'b0});
      end
      @(negedge clk); #2;
      chk(wcnt == DEPTH, "R3 write count", wcnt, DEPTH);
      chk(seq_bad == 0, "R3 ascending order", seq_bad, 0);
      chk(slot_cnt == DEPTH, "R4 strobe cycles used", slot_cnt, DEPTH);
      chk(gate_bad == 0, "R4 writes only on strobe", gate_bad, 0);
      chk(done_cnt == 1, "R5 single done pulse", done_cnt, 1);
      chk(ctl_q[0] == 1'b0 && ctl_q[1] == 1'b1, "R5 start self-cleared",
          32'(ctl_q[1:0]), 2);
      chk(busy == 1'b0, "R8 busy low after sweep", 32'(busy), 0);
      bad = 0;
      for (int a = 0; a < DEPTH; a++) if (model[a] != expw) bad++;
      chk(bad == 0, "R2 stored words", bad, 0);
   endtask

   initial begin
      // R1: reset state
      #7;
      chk(ctl_q == '0, "R1 ctl reset", 32'(ctl_q), 0);
      chk(!busy && !done && !mem_we, "R1 outputs reset",
          {29'b0, busy, done, mem_we}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(ctl_q == '0 && !busy && !done, "R1 after release",
          {ctl_q, 13'b0, busy, done, mem_we}, 0);

      // R8: host write passes while idle
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(3); host_wdata = 16'h0abc;
      #2;
      chk(mem_we && mem_addr == AW'(3) && mem_wdata == 16'h0abc,
          "R8 host passthrough idle", {15'b0, mem_we, mem_wdata}, {16'd1, 16'h0abc});
      @(negedge clk);
      host_we = 1'b0;

      // Table of full sweeps: R2, R3, R4, R5, R8
      for (int v = 0; v < NVEC; v++)
         run_sweep(VEC[v][5:3], int'(VEC[v][2:1]), VEC[v][0]);

      // R6: start without arm
      slot_per = 1;
      clear_model();
      @(negedge clk);
      cfg_wr = 1'b1; cfg_data = {3'b110, 11'b0, 2'b01};
      @(negedge clk);
      cfg_wr = 1'b0;
      #2;
      chk(ctl_q[0] == 1'b1 && !busy, "R6 unarmed start held no busy",
          {30'b0, ctl_q[0], busy}, 2);
      @(negedge clk); #2;
      chk(ctl_q[0] == 1'b0, "R6 unarmed start clears", 32'(ctl_q[0]), 0);
      chk(wcnt == 0, "R6 no writes unarmed", wcnt, 0);

      // R7: abort by dropping arm mid-sweep
      clear_model();
      @(negedge clk);
      cfg_wr = 1'b1; cfg_data = {3'b011, 11'b0, 2'b11};
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (4) @(negedge clk);
      cfg_wr = 1'b1; cfg_data = {3'b011, 11'b0, 2'b01};
      @(negedge clk);
      cfg_wr = 1'b0;
      #2;
      chk(!busy, "R7 busy drops on abort", 32'(busy), 0);
      begin
         int held;
         held = wcnt;
         repeat (3) @(negedge clk);
         #2;
         chk(wcnt == held, "R7 writes stop", wcnt, held);
      end
      chk(ctl_q[0] == 1'b0, "R7 start cleared", 32'(ctl_q[0]), 0);
      chk(done_cnt == 0, "R7 no done on abort", done_cnt, 0);
      chk(wcnt > 0 && wcnt < DEPTH, "R7 partial sweep", wcnt, 5);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule